// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Controller

This block sits between a serial shift engine and a register bus. It buffers received characters and the bytes queued for transmission in two 32-entry FIFOs. From their occupancy it raises interrupt conditions that tell software when to service each side. Every received entry keeps its data byte together with the line-error flags that came with it. An idle timer driven by a character-period tick reports receive bytes that have sat below the threshold for too long.

The serial engine strobes received characters in and pops transmit bytes out. Software pops receive entries, pushes transmit bytes, programs the two levels and the per-source enables, and acknowledges conditions by writing ones to the clear strobe. The four status bits are sticky. A condition that is still true sets its bit again, and a set wins over a clear in the same cycle. The combined interrupt line is the OR of the enabled status bits.

Top module: `uart_fifo_irq`

## Requirements
- R1: While reset is held, both FIFO counts are 0, data-available is 0, all status bits are 0 and the interrupt line is 0.
- R2: The receive head entry is 12 bits: bits 7:0 hold the data, bit 8 framing error, bit 9 parity error, bit 10 overrun, bit 11 break. Entries leave in arrival order.
- R3: Data-available is 1 whenever the receive FIFO holds at least one entry, whatever the receive level.
- R4: Status bit 0 (receive-ready) is set one cycle after the receive count is greater than or equal to the receive level.
- R5: Status bit 2 (transmit-ready) is set one cycle after the number of bytes still queued for transmit is less than or equal to the transmit level.
- R6: Status bit 1 (aging) is set on the 8th character tick counted while the receive FIFO is non-empty. The count restarts on every received character and every pop, and it stays at zero while the FIFO is empty.
- R7: A character that arrives while the receive FIFO is full is dropped, and the next stored entry carries the overrun flag.
- R8: Writing 1 to a bit of the clear strobe clears that status bit on the next edge, unless its condition holds in that cycle. Writing all ones clears every condition that is no longer true.
- R9: The interrupt line is 1 exactly when some status bit is 1 and its enable bit, at the same position, is also 1.
- R10: Status bit 3 (break) is set on the edge where a character arrives with its break flag set.
- R11: Each FIFO holds 32 entries. A push into a full transmit FIFO is ignored, and transmit bytes leave in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_frame_err_i | input | 1 | Framing error for the character |
| rx_parity_err_i | input | 1 | Parity error for the character |
| rx_break_i | input | 1 | Break condition for the character |
| char_tick_i | input | 1 | One pulse per character period |
| rx_pop_i | input | 1 | Bus pops the receive head |
| rx_entry_o | output | 12 | Receive head entry |
| rx_count_o | output | 6 | Receive FIFO occupancy |
| rx_avail_o | output | 1 | Receive data available |
| tx_push_i | input | 1 | Bus pushes a transmit byte |
| tx_data_i | input | 8 | Byte to push |
| tx_pop_i | input | 1 | Serial core takes the transmit head |
| tx_data_o | output | 8 | Transmit head byte |
| tx_valid_o | output | 1 | Transmit FIFO non-empty |
| tx_count_o | output | 6 | Transmit FIFO occupancy |
| rx_level_i | input | 6 | Receive threshold (0 to 32) |
| tx_level_i | input | 6 | Transmit threshold, bytes remaining (0 to 32) |
| irq_en_i | input | 4 | Per-source enables, bit order as status |
| clr_i | input | 4 | Write-1-to-clear strobes for status |
| status_o | output | 4 | Sticky status: 0 rx-ready, 1 aging, 2 tx-ready, 3 break |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that pops arrive only as single-cycle strobes and that a pop of an empty FIFO or a push into a full one is harmless. They also assume that the clear strobe and the level inputs change only between edges. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It fills the FIFOs past capacity on purpose, to show that the excess is dropped without any counter wrapping. Character ticks are issued only when no character or pop is in flight, except where the aging restart itself is under test.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;
  typedef struct packed {
    logic       brk;
    logic       overrun;
    logic       parity_err;
    logic       frame_err;
    logic [7:0] data;
  } rx_entry_t;

  localparam int unsigned ST_RXRDY = 0;
  localparam int unsigned ST_AGE   = 1;
  localparam int unsigned ST_TXRDY = 2;
  localparam int unsigned ST_BRK   = 3;
  localparam int unsigned N_SRC    = 4;
endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             rd_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;
  logic             wr_ok, rd_ok;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = count_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_ok) wptr_q <= nxt(wptr_q);
      if (rd_ok) rptr_q <= nxt(rptr_q);
      if (wr_ok && !rd_ok)      count_q <= count_q + CNT_W'(1);
      else if (rd_ok && !wr_ok) count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  assert_count_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  assert_push_grows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !full_o && !rd_i) |=> (count_q == $past(count_q) + CNT_W'(1)));
  assert_full_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> full_o);
endmodule

// File: rtl/ufi_age_timer.sv
module ufi_age_timer #(
  parameter int unsigned AGE_CHARS = 8,
  localparam int unsigned AW = $clog2(AGE_CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonempty_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  logic [AW-1:0] cnt_q;

  assign expire_o = tick_i && nonempty_i && !restart_i && (cnt_q == AW'(AGE_CHARS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart_i || !nonempty_i)   cnt_q <= '0;
    else if (tick_i && cnt_q != AW'(AGE_CHARS)) cnt_q <= cnt_q + AW'(1);
  end

  // counter only advances while data waits
  assert_idle_when_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> nonempty_i);
  assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned AGE_CHARS = 8,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1),
  localparam int unsigned EW       = $bits(rx_entry_t)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_frame_err_i,
  input  logic             rx_parity_err_i,
  input  logic             rx_break_i,
  input  logic             char_tick_i,
  input  logic             rx_pop_i,
  output logic [EW-1:0]    rx_entry_o,
  output logic [LVL_W-1:0] rx_count_o,
  output logic             rx_avail_o,
  input  logic             tx_push_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_pop_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic [LVL_W-1:0] tx_count_o,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o,
  output logic             irq_o
);
  rx_entry_t        rx_wdata;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             ovr_pend_q, age_expire;
  logic [N_SRC-1:0] set_vec, status_q;

  assign rx_wdata = '{brk: rx_break_i, overrun: ovr_pend_q, parity_err: rx_parity_err_i,
                      frame_err: rx_frame_err_i, data: rx_data_i};

  ufi_fifo #(.W(EW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .wr_i(rx_valid_i), .wdata_i(rx_wdata), .rd_i(rx_pop_i),
    .rdata_o(rx_entry_o), .count_o(rx_count_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  ufi_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .wr_i(tx_push_i), .wdata_i(tx_data_i), .rd_i(tx_pop_i),
    .rdata_o(tx_data_o), .count_o(tx_count_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  ufi_age_timer #(.AGE_CHARS(AGE_CHARS)) u_age (
    .clk_i, .rst_ni, .nonempty_i(!rx_empty), .restart_i(rx_valid_i || rx_pop_i),
    .tick_i(char_tick_i), .expire_o(age_expire)
  );

  // overrun is reported on the next entry that fits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_pend_q <= 1'b0;
    else if (rx_valid_i)         ovr_pend_q <= rx_full;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[ST_RXRDY] = (rx_count_o >= rx_level_i);
    set_vec[ST_AGE]   = age_expire;
    set_vec[ST_TXRDY] = (tx_count_o <= tx_level_i);
    set_vec[ST_BRK]   = rx_valid_i && rx_break_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_vec;
  end

  assign status_o   = status_q;
  assign irq_o      = |(status_q & irq_en_i);
  assign rx_avail_o = !rx_empty;
  assign tx_valid_o = !tx_empty;

  assert_age_needs_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_AGE]) |-> $past(!rx_empty));
  assert_brk_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_BRK]) |-> $past(rx_valid_i && rx_break_i));
  assert_brk_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[ST_BRK] && !(rx_valid_i && rx_break_i)) |=> !status_q[ST_BRK]);
  assert_txrdy_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_TXRDY]) |-> $past(tx_count_o <= tx_level_i));
  assert_ovr_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_full) |=> ovr_pend_q);
endmodule

// File: tb/uart_fifo_irq_tb.sv
`timescale 1ns/1ps
module uart_fifo_irq_tb;
  localparam int DEPTH = 32;

  logic        clk = 0, rst_ni = 0;
  logic        rx_valid_i = 0, rx_frame_err_i = 0, rx_parity_err_i = 0, rx_break_i = 0;
  logic [7:0]  rx_data_i = 0, tx_data_i = 0;
  logic        char_tick_i = 0, rx_pop_i = 0, tx_push_i = 0, tx_pop_i = 0;
  logic [11:0] rx_entry_o;
  logic [5:0]  rx_count_o, tx_count_o;
  logic [5:0]  rx_level_i = 6'd4, tx_level_i = 6'd2;
  logic [3:0]  irq_en_i = 0, clr_i = 0, status_o;
  logic [7:0]  tx_data_o;
  logic        rx_avail_o, tx_valid_o, irq_o;

  int total = 0, fails = 0;
  bit done = 0, ovr_exp = 0;
  logic [11:0] rxq[$];
  logic [7:0]  txq[$];

  always #4 clk = ~clk;

  uart_fifo_irq u_dut (
    .clk_i(clk), .rst_ni, .rx_valid_i, .rx_data_i, .rx_frame_err_i, .rx_parity_err_i,
    .rx_break_i, .char_tick_i, .rx_pop_i, .rx_entry_o, .rx_count_o, .rx_avail_o,
    .tx_push_i, .tx_data_i, .tx_pop_i, .tx_data_o, .tx_valid_o, .tx_count_o,
    .rx_level_i, .tx_level_i, .irq_en_i, .clr_i, .status_o, .irq_o
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: sends one character and records what the FIFO should hold
  task automatic rx_write(input logic [7:0] d, input logic fe, input logic pe, input logic brk);
    rx_valid_i = 1; rx_data_i = d; rx_frame_err_i = fe; rx_parity_err_i = pe; rx_break_i = brk;
    if (rxq.size() < DEPTH) begin
      rxq.push_back({brk, ovr_exp, pe, fe, d});
      ovr_exp = 0;
    end else ovr_exp = 1;
    @(negedge clk);
    rx_valid_i = 0; rx_break_i = 0;
  endtask

  // monitor: compares the head with the scoreboard, then pops it
  task automatic rx_pop_check(input string req);
    logic [11:0] e;
    e = rxq.pop_front();
    chk(req, rx_entry_o, e);
    rx_pop_i = 1;
    @(negedge clk);
    rx_pop_i = 0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_push_i = 1; tx_data_i = d;
    if (txq.size() < DEPTH) txq.push_back(d);
    @(negedge clk);
    tx_push_i = 0;
  endtask

  task automatic tx_pop_check(input string req);
    logic [7:0] e;
    e = txq.pop_front();
    chk(req, tx_data_o, e);
    tx_pop_i = 1;
    @(negedge clk);
    tx_pop_i = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      char_tick_i = 1;
      @(negedge clk);
      char_tick_i = 0;
    end
  endtask

  task automatic clear(input logic [3:0] m);
    clr_i = m;
    @(negedge clk);
    clr_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(2);
    chk("R1 rx count", rx_count_o, 0);
    chk("R1 tx count", tx_count_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 avail", rx_avail_o, 0);
    rst_ni = 1;
    idle(2);
    clear(4'hF);

    // threshold on receive side, level 4
    rx_write(8'hA1, 1, 0, 0);
    chk("R3 avail after one entry", rx_avail_o, 1);
    rx_write(8'hB2, 0, 1, 0);
    rx_write(8'hC3, 1, 1, 0);
    idle(1);
    chk("R4 below level", status_o[0], 0);
    rx_write(8'hD4, 0, 0, 0);
    idle(1);
    chk("R4 at level", status_o[0], 1);
    chk("R9 masked source", irq_o, 0);
    irq_en_i = 4'b0001; #1;
    chk("R9 enabled source", irq_o, 1);
    irq_en_i = 4'b0010; #1;
    chk("R9 other enable only", irq_o, 0);
    irq_en_i = 0;
    clear(4'b0001);
    chk("R8 set wins while level met", status_o[0], 1);
    repeat (4) rx_pop_check("R2 entry order and flags");
    chk("R3 avail when empty", rx_avail_o, 0);
    clear(4'b0001);
    chk("R8 clear after level gone", status_o[0], 0);

    // aging
    rx_write(8'h11, 0, 0, 0);
    tick(7);
    idle(1);
    chk("R6 seven ticks", status_o[1], 0);
    rx_write(8'h22, 0, 0, 0);
    tick(7);
    idle(1);
    chk("R6 restart on new char", status_o[1], 0);
    tick(1);
    chk("R6 eighth tick", status_o[1], 1);
    rx_pop_check("R2 aged entry");
    rx_pop_check("R2 aged entry");
    clear(4'b0010);
    tick(10);
    idle(1);
    chk("R6 no aging when empty", status_o[1], 0);

    // overrun with level out of reach
    rx_level_i = 6'd33;
    for (int i = 0; i < DEPTH + 2; i++) rx_write(8'(i + 8'h40), i[0], i[1], 0);
    chk("R11 rx capacity", rx_count_o, 32);
    for (int i = 0; i < DEPTH; i++) rx_pop_check("R7 kept entries");
    rx_write(8'h77, 0, 0, 0);
    rx_write(8'h78, 0, 0, 0);
    chk("R7 expected overrun flagged", rxq[0][10], 1);
    rx_pop_check("R7 overrun on next entry");
    rx_pop_check("R7 flag only once");
    idle(1);
    chk("R4 level 33 never met", status_o[0], 0);

    // transmit threshold counts bytes remaining
    for (int i = 0; i < 5; i++) tx_push(8'(8'h90 + i));
    clear(4'b0100);
    chk("R5 five queued above level 2", status_o[2], 0);
    tx_pop_check("R11 tx order");
    tx_pop_check("R11 tx order");
    idle(1);
    chk("R5 three queued", status_o[2], 0);
    tx_pop_check("R11 tx order");
    idle(1);
    chk("R5 two queued", status_o[2], 1);
    tx_pop_check("R11 tx order");
    tx_pop_check("R11 tx order");
    for (int i = 0; i < DEPTH + 1; i++) tx_push(8'(i * 3));
    chk("R11 tx capacity", tx_count_o, 32);
    for (int i = 0; i < DEPTH; i++) tx_pop_check("R11 tx full drain");
    chk("R11 tx empty", tx_valid_o, 0);

    // break
    clear(4'hF);
    chk("R10 no break yet", status_o[3], 0);
    rx_write(8'h00, 1, 0, 1);
    chk("R10 break set", status_o[3], 1);
    irq_en_i = 4'b1000; #1;
    chk("R9 break irq", irq_o, 1);
    clear(4'hF);
    chk("R8 all ones clears break", status_o[3], 0);
    chk("R9 irq drops", irq_o, 0);
    rx_pop_check("R2 break entry");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule